// File: doc/BRIEF.md
# Smart card reset and answer timing supervisor

This block controls the reset line of a single contact smart card slot and times the card's first response. Software first brings the slot up: it sets the supply, waits for the supply-good indication and starts the card clock. It then raises a reset request. From that moment the block counts card clock cycles, which it receives as a one-cycle enable pulse in the system clock domain. It holds the card in reset until the count reaches a programmed 16-bit threshold, then releases reset, clears the count and times how long the card takes to pull its I/O line low for the first start bit of its answer.

Three outcomes are possible. An answer that starts after release ends the sequence successfully, and the count stops at the answer time so software can read it. A start bit seen while reset is still held counts as an early-answer failure. No start bit before a programmable answer timeout counts as a no-answer failure. Either failure drives reset active again, sets a sticky error flag and pulls an active-low interrupt. Activity on the I/O line during a fixed window of 200 card clocks after the request is disregarded. Dropping the request at any time returns the slot to idle.

Top module: `scard_rst_sup`

## Requirements
- R1: After reset, and whenever idle, `card_rst` is 0 (card held in reset), `cnt_val` is 0, `done_ok`, `err_early`, `err_noans` and `err_sticky` are 0 and `irq_n` is 1.
- R2: A sequence starts only on a clock edge where `rst_req` is 1, was 0 on the previous edge, and both `supply_ok` and `clk_run` are 1; a rising request without both flags is ignored until the request is dropped and raised again.
- R3: The threshold is `{thr_hi, thr_lo}` with `thr_hi` as bits 15:8. `cnt_val` counts `card_clk_en` pulses from the start edge, and `card_rst` becomes 1 on the edge after the one where `cnt_val` equals the threshold; with `card_clk_en` held at 1 and `rst_req` raised just after an edge, `card_rst` reads 0 for threshold+1 edges and 1 after edge threshold+2.
- R4: At the edge where `card_rst` becomes 1, `cnt_val` is cleared to 0 and then counts `card_clk_en` pulses again.
- R5: `card_io` passes two synchronising flops and one edge flop; a high-to-low change made just after edge k is acted on at edge k+3.
- R6: Falling edges of `card_io` are disregarded until 200 `card_clk_en` pulses have been counted since the start edge, both while reset is held and after release.
- R7: A falling edge of `card_io` after the blanking window while `card_rst` is still 0 sets `err_early`, keeps `card_rst` at 0 and stops the count.
- R8: A falling edge after the blanking window while `card_rst` is 1 sets `done_ok`, keeps `card_rst` at 1 and freezes `cnt_val` at the number of pulses counted since release.
- R9: If `cnt_val` reaches `ans_tmo` after release with no answer, `err_noans` is set, `card_rst` returns to 0 and the count stops at `ans_tmo`; an answer acted on at that same edge wins and gives `done_ok`.
- R10: Either failure sets `err_sticky`, and `irq_n` is 0 exactly while `err_sticky` is 1; a one-cycle `err_clr` pulse clears it, and a failure on the same edge as `err_clr` leaves it set.
- R11: Dropping `rst_req` returns the block to idle on the next edge from any state: `card_rst` 0, `cnt_val` 0, `done_ok`, `err_early` and `err_noans` 0, while `err_sticky` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_clk_en | input | 1 | One-cycle pulse per card clock cycle |
| supply_ok | input | 1 | Card supply has settled |
| clk_run | input | 1 | Card clock is running |
| rst_req | input | 1 | Software reset request, level |
| thr_hi | input | 8 | Reset threshold, upper byte |
| thr_lo | input | 8 | Reset threshold, lower byte |
| ans_tmo | input | 16 | Answer timeout in card clocks after release |
| card_io | input | 1 | Card I/O line, asynchronous |
| err_clr | input | 1 | Pulse that clears the sticky error |
| card_rst | output | 1 | Card reset line, 0 while the card is held in reset |
| cnt_val | output | 16 | Current or frozen card clock count |
| done_ok | output | 1 | Answer started in time |
| err_early | output | 1 | Answer started while reset was still held |
| err_noans | output | 1 | No answer before the timeout |
| err_sticky | output | 1 | Sticky failure flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The answer detector and the answer timeout can act on the same edge, and the design must then report success. The bench provokes this by watching for the release edge at every clock, then lowering the I/O line exactly so that the synchronised edge arrives on the timeout edge; it expects `done_ok` with the count frozen at the timeout value. The same stimulus moved one cycle later must produce `err_noans`, which pins the latency of both paths. A clear pulse placed on the timeout edge is also checked, and must leave the sticky flag set.

// File: rtl/scard_sup_pkg.sv
package scard_sup_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_HOLD       = 3'd1,
      ST_WAIT       = 3'd2,
      ST_DONE       = 3'd3,
      ST_FAIL_EARLY = 3'd4,
      ST_FAIL_NOANS = 3'd5
   } seq_state_e;

endpackage

// File: rtl/scard_io_edge.sv
module scard_io_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic io_raw,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("scard_io_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   // Shift chain, idle-high line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], io_raw};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign fall = last_q & ~sync_q[STAGES-1];

   // R5: a detected edge lasts exactly one cycle
   a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/scard_blank_timer.sv
module scard_blank_timer #(
   parameter int BLANK_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic done
);

   localparam int BW = $clog2(BLANK_CYC + 1);

   if (BLANK_CYC < 1) begin : g_bad_blank
      $error("scard_blank_timer: BLANK_CYC must be positive");
   end

   logic [BW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (tick && !done)
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == BW'(BLANK_CYC));

   // R6: once open, the window stays open until cleared
   a_r6_blank_sat: assert property (@(posedge clk) disable iff (!rst_n)
      done && !clr |=> done);

endmodule

// File: rtl/scard_cycle_ctr.sv
module scard_cycle_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   if (W < 2) begin : g_bad_width
      $error("scard_cycle_ctr: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + 1'b1;
   end

   // R3: one step per granted pulse
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !clr |=> cnt == $past(cnt) + 1'b1);

   // R8: count holds when neither cleared nor advanced
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc && !clr |=> $stable(cnt));

endmodule

// File: rtl/scard_seq_fsm.sv
module scard_seq_fsm
   import scard_sup_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rst_req,
   input  logic         supply_ok,
   input  logic         clk_run,
   input  logic         tick,
   input  logic         fall,
   input  logic         blank_done,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] thr,
   input  logic [W-1:0] tmo,
   input  logic         err_clr,
   output logic         cnt_clr,
   output logic         cnt_inc,
   output logic         blank_clr,
   output logic         released,
   output logic         done_ok,
   output logic         err_early,
   output logic         err_noans,
   output logic         err_sticky
);

   seq_state_e state_q, state_d;
   logic       req_q;
   logic       start;
   logic       hit;
   logic       set_fail;

   assign start = rst_req & ~req_q & supply_ok & clk_run;
   assign hit   = fall & blank_done;

   always_comb begin
      state_d  = state_q;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      set_fail = 1'b0;
      case (state_q)
         ST_IDLE: begin
            cnt_clr = 1'b1;
            if (start) state_d = ST_HOLD;
         end
         ST_HOLD: begin
            // early answer outranks the threshold match
            if (hit) begin
               state_d  = ST_FAIL_EARLY;
               set_fail = 1'b1;
            end else if (cnt == thr) begin
               state_d = ST_WAIT;
               cnt_clr = 1'b1;
            end else begin
               cnt_inc = tick;
            end
         end
         ST_WAIT: begin
            // answer outranks the timeout
            if (hit) begin
               state_d = ST_DONE;
            end else if (cnt == tmo) begin
               state_d  = ST_FAIL_NOANS;
               set_fail = 1'b1;
            end else begin
               cnt_inc = tick;
            end
         end
         default: ;
      endcase
      if (state_q != ST_IDLE && !rst_req) begin
         state_d  = ST_IDLE;
         cnt_clr  = 1'b1;
         cnt_inc  = 1'b0;
         set_fail = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         req_q      <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         state_q <= state_d;
         req_q   <= rst_req;
         if (set_fail)
            err_sticky <= 1'b1;
         else if (err_clr)
            err_sticky <= 1'b0;
      end
   end

   assign blank_clr = (state_q == ST_IDLE);
   assign released  = (state_q == ST_WAIT) || (state_q == ST_DONE);
   assign done_ok   = (state_q == ST_DONE);
   assign err_early = (state_q == ST_FAIL_EARLY);
   assign err_noans = (state_q == ST_FAIL_NOANS);

   // R3: release happens only after the count met the threshold
   a_r3_release_at_thr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(released) |-> $past(cnt) == $past(thr));

   // R4: the count restarts from zero at release
   a_r4_zero_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(released) |-> cnt == '0);

   // R7: an early failure needs an open blanking window
   a_r7_early_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_early) |-> $past(blank_done));

   // R8: the answer time stays frozen while the request is held
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok && rst_req |=> $stable(cnt));

   // R9: a timeout fires only on the programmed count
   a_r9_noans_at_tmo: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_noans) |-> $past(cnt) == $past(tmo));

   // R10: sticky flag survives until cleared
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky && !err_clr |=> err_sticky);

   // R11: dropping the request aborts to idle
   a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_req |=> !released && cnt == '0 && !done_ok && !err_early && !err_noans);

endmodule

// File: rtl/scard_rst_sup.sv
module scard_rst_sup #(
   parameter int THR_BYTE_W     = 8,
   parameter int BLANK_CYC      = 200,
   parameter int SYNC_STAGES    = 2,
   parameter bit RST_ACTIVE_LOW = 1'b1,
   localparam int CNT_W         = 2 * THR_BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  card_clk_en,
   input  logic                  supply_ok,
   input  logic                  clk_run,
   input  logic                  rst_req,
   input  logic [THR_BYTE_W-1:0] thr_hi,
   input  logic [THR_BYTE_W-1:0] thr_lo,
   input  logic [CNT_W-1:0]      ans_tmo,
   input  logic                  card_io,
   input  logic                  err_clr,
   output logic                  card_rst,
   output logic [CNT_W-1:0]      cnt_val,
   output logic                  done_ok,
   output logic                  err_early,
   output logic                  err_noans,
   output logic                  err_sticky,
   output logic                  irq_n
);

   if (THR_BYTE_W < 2) begin : g_bad_byte
      $error("scard_rst_sup: THR_BYTE_W too small");
   end
   if (BLANK_CYC >= (1 << CNT_W)) begin : g_bad_window
      $error("scard_rst_sup: BLANK_CYC exceeds the counter range");
   end

   logic [CNT_W-1:0] thr;
   logic             fall;
   logic             blank_done;
   logic             blank_clr;
   logic             cnt_clr;
   logic             cnt_inc;
   logic             released;

   assign thr = {thr_hi, thr_lo};

   scard_io_edge #(
      .STAGES (SYNC_STAGES)
   ) u_io_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .io_raw (card_io),
      .fall   (fall)
   );

   scard_blank_timer #(
      .BLANK_CYC (BLANK_CYC)
   ) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (blank_clr),
      .tick  (card_clk_en),
      .done  (blank_done)
   );

   scard_cycle_ctr #(
      .W (CNT_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (cnt_val)
   );

   scard_seq_fsm #(
      .W (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_req    (rst_req),
      .supply_ok  (supply_ok),
      .clk_run    (clk_run),
      .tick       (card_clk_en),
      .fall       (fall),
      .blank_done (blank_done),
      .cnt        (cnt_val),
      .thr        (thr),
      .tmo        (ans_tmo),
      .err_clr    (err_clr),
      .cnt_clr    (cnt_clr),
      .cnt_inc    (cnt_inc),
      .blank_clr  (blank_clr),
      .released   (released),
      .done_ok    (done_ok),
      .err_early  (err_early),
      .err_noans  (err_noans),
      .err_sticky (err_sticky)
   );

   // Pad level picked by polarity option
   if (RST_ACTIVE_LOW) begin : g_rst_low
      assign card_rst = released;
   end else begin : g_rst_high
      assign card_rst = ~released;
   end

   assign irq_n = ~err_sticky;

   // R7, R9: any failure leaves the card held in reset
   a_r7_fail_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (err_early || err_noans) |-> (card_rst == ~RST_ACTIVE_LOW));

   // R10: interrupt follows a newly raised sticky flag
   a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_sticky) |-> !irq_n);

endmodule

// File: tb/test_scard_rst_sup.sv
module test_scard_rst_sup;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        card_clk_en = 1'b1;
   logic        supply_ok = 1'b1;
   logic        clk_run = 1'b1;
   logic        rst_req = 1'b0;
   logic [7:0]  thr_hi = 8'd0;
   logic [7:0]  thr_lo = 8'd0;
   logic [15:0] ans_tmo = 16'd1000;
   logic        card_io = 1'b1;
   logic        err_clr = 1'b0;
   logic        card_rst;
   logic [15:0] cnt_val;
   logic        done_ok;
   logic        err_early;
   logic        err_noans;
   logic        err_sticky;
   logic        irq_n;

   int n_vec = 0;
   int n_bad = 0;
   int div = 1;
   int div_ctr = 0;
   bit fin = 1'b0;

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (div_ctr >= div - 1) begin
         div_ctr     <= 0;
         card_clk_en <= 1'b1;
      end else begin
         div_ctr     <= div_ctr + 1;
         card_clk_en <= 1'b0;
      end
   end

   scard_rst_sup i_scard_rst_sup (
      .clk         (clk),
      .rst_n       (rst_n),
      .card_clk_en (card_clk_en),
      .supply_ok   (supply_ok),
      .clk_run     (clk_run),
      .rst_req     (rst_req),
      .thr_hi      (thr_hi),
      .thr_lo      (thr_lo),
      .ans_tmo     (ans_tmo),
      .card_io     (card_io),
      .err_clr     (err_clr),
      .card_rst    (card_rst),
      .cnt_val     (cnt_val),
      .done_ok     (done_ok),
      .err_early   (err_early),
      .err_noans   (err_noans),
      .err_sticky  (err_sticky),
      .irq_n       (irq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      n_vec++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic set_thr(input int t);
      thr_hi = 8'((t >> 8) & 255);
      thr_lo = 8'(t & 255);
   endtask

   task automatic wait_rel(input int lim, output int n);
      n = 0;
      while (card_rst !== 1'b1 && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      rst_req = 1'b0;
      card_io = 1'b1;
      repeat (6) @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      div = 1;
      supply_ok = 1'b1;
      clk_run = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 card_rst", card_rst, 0);
      chk("R1 cnt_val", cnt_val, 0);
      chk("R1 irq_n", irq_n, 1);
      chk("R1 flags", {done_ok, err_early, err_noans, err_sticky}, 0);
   endtask

   task automatic t_release_exact(input int t);
      bit early = 1'b0;
      set_thr(t);
      rst_req = 1'b1;
      for (int k = 0; k < t + 1; k++) begin
         @(negedge clk);
         if (card_rst !== 1'b0) early = 1'b1;
      end
      chk("R3 held until threshold", early, 0);
      @(negedge clk);
      chk("R3 released at threshold", card_rst, 1);
      chk("R4 count cleared at release", cnt_val, 0);
      @(negedge clk);
      chk("R4 count restarts", cnt_val, 1);
      go_idle();
   endtask

   task automatic t_gate();
      int n;
      set_thr(3);
      supply_ok = 1'b0;
      rst_req = 1'b1;
      repeat (10) @(negedge clk);
      chk("R2 no start without supply", card_rst, 0);
      supply_ok = 1'b1;
      repeat (10) @(negedge clk);
      chk("R2 level alone does not start", card_rst, 0);
      rst_req = 1'b0;
      @(negedge clk);
      rst_req = 1'b1;
      wait_rel(20, n);
      chk("R2 fresh request starts", n, 5);
      go_idle();
      clk_run = 1'b0;
      rst_req = 1'b1;
      repeat (10) @(negedge clk);
      chk("R2 no start without clock", card_rst, 0);
      go_idle();
   endtask

   task automatic t_blank_hold();
      int n;
      set_thr(400);
      rst_req = 1'b1;
      repeat (50) @(negedge clk);
      card_io = 1'b0;
      repeat (20) @(negedge clk);
      card_io = 1'b1;
      wait_rel(600, n);
      chk("R6 blanked edge ignored in hold", card_rst, 1);
      chk("R6 no early flag", err_early, 0);
      chk("R3 release time", n, 332);
      go_idle();
   endtask

   task automatic t_early();
      logic [15:0] snap;
      set_thr(1000);
      rst_req = 1'b1;
      repeat (300) @(negedge clk);
      card_io = 1'b0;
      repeat (6) @(negedge clk);
      chk("R7 early flag", err_early, 1);
      chk("R7 reset kept", card_rst, 0);
      chk("R10 sticky set", err_sticky, 1);
      chk("R10 irq low", irq_n, 0);
      snap = cnt_val;
      repeat (5) @(negedge clk);
      chk("R7 count stopped", cnt_val, snap);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk("R10 cleared by pulse", err_sticky, 0);
      chk("R10 irq released", irq_n, 1);
      chk("R7 outcome kept", err_early, 1);
      go_idle();
   endtask

   task automatic t_answer();
      int n;
      set_thr(300);
      ans_tmo = 16'd1000;
      rst_req = 1'b1;
      wait_rel(400, n);
      repeat (17) @(negedge clk);
      card_io = 1'b0;
      repeat (2) @(negedge clk);
      chk("R5 not yet acted", done_ok, 0);
      @(negedge clk);
      chk("R5 acted after three edges", done_ok, 1);
      chk("R8 reset stays released", card_rst, 1);
      chk("R8 answer time", cnt_val, 19);
      repeat (10) @(negedge clk);
      chk("R8 answer time frozen", cnt_val, 19);
      go_idle();
   endtask

   task automatic t_tie();
      int n;
      set_thr(250);
      ans_tmo = 16'd40;
      rst_req = 1'b1;
      wait_rel(400, n);
      repeat (38) @(negedge clk);
      card_io = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 answer wins tie", done_ok, 1);
      chk("R9 no timeout on tie", err_noans, 0);
      chk("R9 tie count", cnt_val, 40);
      go_idle();
   endtask

   task automatic t_late();
      int n;
      set_thr(250);
      ans_tmo = 16'd40;
      rst_req = 1'b1;
      wait_rel(400, n);
      repeat (39) @(negedge clk);
      card_io = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 timeout flag", err_noans, 1);
      chk("R9 reset reasserted", card_rst, 0);
      chk("R9 count at timeout", cnt_val, 40);
      chk("R10 irq on timeout", irq_n, 0);
      rst_req = 1'b0;
      @(negedge clk);
      chk("R11 outcome cleared", err_noans, 0);
      chk("R11 sticky kept", err_sticky, 1);
      chk("R11 count cleared", cnt_val, 0);
      go_idle();
   endtask

   task automatic t_blank_wait();
      int n;
      set_thr(20);
      ans_tmo = 16'd2000;
      rst_req = 1'b1;
      wait_rel(100, n);
      repeat (5) @(negedge clk);
      card_io = 1'b0;
      repeat (60) @(negedge clk);
      chk("R6 blanked edge ignored after release", done_ok, 0);
      chk("R6 still released", card_rst, 1);
      card_io = 1'b1;
      repeat (200) @(negedge clk);
      card_io = 1'b0;
      repeat (5) @(negedge clk);
      chk("R6 edge accepted after window", done_ok, 1);
      go_idle();
   endtask

   task automatic t_clr_tie();
      int n;
      set_thr(250);
      ans_tmo = 16'd30;
      rst_req = 1'b1;
      wait_rel(400, n);
      repeat (30) @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk("R10 set wins over clear", err_sticky, 1);
      chk("R9 timeout on clear edge", err_noans, 1);
      go_idle();
   endtask

   task automatic t_abort();
      int n;
      set_thr(250);
      ans_tmo = 16'd1000;
      rst_req = 1'b1;
      wait_rel(400, n);
      repeat (10) @(negedge clk);
      rst_req = 1'b0;
      @(negedge clk);
      chk("R11 reset reasserted", card_rst, 0);
      chk("R11 count zero", cnt_val, 0);
      chk("R11 no outcome", {done_ok, err_early, err_noans}, 0);
      go_idle();
   endtask

   task automatic t_div();
      int n;
      div = 3;
      set_thr(20);
      @(negedge clk);
      rst_req = 1'b1;
      wait_rel(200, n);
      chk_rng("R3 divided card clock", n, 58, 66);
      go_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_release_exact(5);
      t_release_exact(0);
      t_release_exact(259);
      t_gate();
      t_blank_hold();
      t_early();
      t_answer();
      t_tie();
      t_late();
      t_blank_wait();
      t_clr_tie();
      t_abort();
      t_div();
      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule